// File: doc/BRIEF.md
# NAND Bus Strobe Sequencer

This block turns single bus-cycle requests (command, address, data write, data read) into the chip-enable, latch-enable and read/write strobe waveforms of a raw NAND flash interface. Every phase of a cycle takes a count from a configuration input, in interface-clock cycles. The block holds chip enable active before the first strobe edge, sets the low and high widths of the strobe, and samples the read data bus at a programmed point after the read strobe falls. When one cycle type follows another and the flash needs a pause between them, the block inserts that pause itself. The host only issues requests over a valid/ready handshake.

The sequencer is a five-state machine. `ST_IDLE` raises ready. On an accepted request it goes to `ST_GAP` when the previous cycle type and the new one call for a turnaround pause, or else straight to `ST_SETUP`. `ST_GAP` moves to `ST_SETUP` when its count ends. `ST_SETUP` (chip enable low, strobes high) moves to `ST_LOW` (one strobe low) and then to `ST_HIGH` (strobe high, chip enable still low). `ST_HIGH` returns to `ST_IDLE` and records the type of the cycle just finished for the next gap decision. Chip enable is high in `ST_IDLE` and `ST_GAP`. The interface clock is expected to be 4 to 6 times the core clock. `CLK_MULT` gives that ratio and sets a floor on the strobe period. With `A2D_NARROW` set, the top bit of the address-to-data count is ignored, for a 6-bit field.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, chip enable and both strobes are high, both latch enables are low, the data bus is not driven, rd_valid is low and req_ready is high.
- R2: req_type selects the cycle: 0 is command (CLE high), 1 is address (ALE high), 2 is data write and 3 is data read (neither latch high). CLE or ALE stays high for every clock in which chip enable is low for that cycle. For types 0 to 2 the bus carries req_data and is driven, and WE# pulses. For type 3 the bus is released and RE# pulses.
- R3: Chip enable is low for exactly cfg_cs_setup clocks before the strobe falls.
- R4: The strobe (WE# or RE#) stays low for cfg_lo clocks, then high for cfg_hi clocks before chip enable rises.
- R5: If cfg_lo + cfg_hi is less than CLK_MULT, the low phase is lengthened so that low plus high equals CLK_MULT.
- R6: On a read, dq_in is captured at the cfg_acc-th rising clock edge after RE# falls. If cfg_acc exceeds the low width, RE# stays low for cfg_acc clocks. The captured byte appears on rd_data with a one-clock rd_valid pulse.
- R7: A read that follows a command or data write is preceded by chip enable high for 1 + cfg_w2r clocks.
- R8: A command, address or data write that follows a read is preceded by chip enable high for 1 + cfg_r2w clocks.
- R9: A read that follows a read is preceded by chip enable high for 1 + cfg_r2r clocks.
- R10: A data write or read that follows an address cycle is preceded by chip enable high for 1 + cfg_a2d clocks, and all 7 bits of cfg_a2d are honoured.
- R11: Any other pair of cycle types, and the first request after reset, has chip enable high for exactly one clock between back-to-back cycles.
- R12: A count of zero in any configuration field acts as one clock.
- R13: req_ready is high only while chip enable and both strobes are high. It drops in the clock after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Sequencer idle, request accepted this clock if valid |
| req_type | input | 2 | Cycle type: 0 command, 1 address, 2 write, 3 read |
| req_data | input | DATA_W | Byte driven for command, address or write |
| cfg_cs_setup | input | CNT_W | Chip-enable setup clocks |
| cfg_lo | input | CNT_W | Strobe low clocks |
| cfg_hi | input | CNT_W | Strobe high clocks |
| cfg_acc | input | CNT_W | Read sample point after RE# falls |
| cfg_w2r | input | CNT_W | Command/write to read gap |
| cfg_r2w | input | CNT_W | Read to non-read gap |
| cfg_r2r | input | CNT_W | Read to read gap |
| cfg_a2d | input | A2D_W | Address to data gap |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | DATA_W | Bus data out |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | DATA_W | Bus data in |
| rd_valid | output | 1 | One-clock pulse with captured read byte |
| rd_data | output | DATA_W | Captured read byte |

## Verification
The assertions assume that the configuration inputs hold still while a cycle is in progress and that req_type and req_data are stable while req_valid waits for ready. The stimulus changes configuration only after the request queue has drained and the block has sat idle for several clocks. It drives request fields on the falling edge and holds them until acceptance. The read bus model drives a value that encodes the read number and the number of clocks RE# has been low. This lets the sampling point be checked exactly.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_WR   = 2'd2,
        CYC_RD   = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } seq_state_e;
endpackage

// File: rtl/nsg_phase_timer.sv
module nsg_phase_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] elapsed,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       elapsed <= '0;
        else if (restart) elapsed <= '0;
        else              elapsed <= elapsed + 1'b1;
    end

    // len is never below one, so len-1 does not wrap
    assign last = (elapsed >= len - 1'b1);
endmodule

// File: rtl/nsg_gap_sel.sv
module nsg_gap_sel import nsg_pkg::*; #(
    parameter int CNT_W = 6,
    parameter int A2D_W = 7,
    parameter int LEN_W = 8
) (
    input  logic              prev_vld,
    input  cyc_kind_e         prev_kind,
    input  cyc_kind_e         new_kind,
    input  logic [CNT_W-1:0]  w2r_cfg,
    input  logic [CNT_W-1:0]  r2w_cfg,
    input  logic [CNT_W-1:0]  r2r_cfg,
    input  logic [A2D_W-1:0]  a2d_cfg,
    output logic              need,
    output logic [LEN_W-1:0]  len
);
    logic [CNT_W-1:0] pick;
    logic [A2D_W-1:0] pick_a2d;
    logic             use_a2d;

    always_comb begin
        need     = 1'b0;
        use_a2d  = 1'b0;
        pick     = '0;
        pick_a2d = a2d_cfg;
        if (prev_vld) begin
            if (new_kind == CYC_RD) begin
                need = 1'b1;
                unique case (prev_kind)
                    CYC_RD:   pick    = r2r_cfg;
                    CYC_ADDR: use_a2d = 1'b1;
                    default:  pick    = w2r_cfg;
                endcase
            end else if (prev_kind == CYC_RD) begin
                need = 1'b1;
                pick = r2w_cfg;
            end else if (prev_kind == CYC_ADDR && new_kind == CYC_WR) begin
                need    = 1'b1;
                use_a2d = 1'b1;
            end
        end
        if (use_a2d) len = (pick_a2d == '0) ? LEN_W'(1) : LEN_W'(pick_a2d);
        else         len = (pick == '0)     ? LEN_W'(1) : LEN_W'(pick);
    end
endmodule

// File: rtl/nsg_len_calc.sv
module nsg_len_calc #(
    parameter int CNT_W    = 6,
    parameter int LEN_W    = 8,
    parameter int CLK_MULT = 4
) (
    input  logic [CNT_W-1:0] lo_cfg,
    input  logic [CNT_W-1:0] hi_cfg,
    input  logic [CNT_W-1:0] acc_cfg,
    input  logic [CNT_W-1:0] cs_cfg,
    input  logic             is_read,
    output logic [LEN_W-1:0] low_len,
    output logic [LEN_W-1:0] high_len,
    output logic [LEN_W-1:0] acc_len,
    output logic [LEN_W-1:0] cs_len
);
    localparam logic [LEN_W-1:0] MULT_L = LEN_W'(CLK_MULT);

    logic [LEN_W-1:0] lo_e, floor_lo, base_lo;

    always_comb begin
        lo_e     = (lo_cfg  == '0) ? LEN_W'(1) : LEN_W'(lo_cfg);
        high_len = (hi_cfg  == '0) ? LEN_W'(1) : LEN_W'(hi_cfg);
        acc_len  = (acc_cfg == '0) ? LEN_W'(1) : LEN_W'(acc_cfg);
        cs_len   = (cs_cfg  == '0) ? LEN_W'(1) : LEN_W'(cs_cfg);
        floor_lo = (high_len >= MULT_L) ? LEN_W'(1) : (MULT_L - high_len);
        base_lo  = (lo_e > floor_lo) ? lo_e : floor_lo;
        low_len  = (is_read && acc_len > base_lo) ? acc_len : base_lo;
    end
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen import nsg_pkg::*; #(
    parameter int CNT_W      = 6,
    parameter int A2D_W      = 7,
    parameter int DATA_W     = 8,
    parameter int CLK_MULT   = 4,
    parameter bit A2D_NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CNT_W-1:0]  cfg_cs_setup,
    input  logic [CNT_W-1:0]  cfg_lo,
    input  logic [CNT_W-1:0]  cfg_hi,
    input  logic [CNT_W-1:0]  cfg_acc,
    input  logic [CNT_W-1:0]  cfg_w2r,
    input  logic [CNT_W-1:0]  cfg_r2w,
    input  logic [CNT_W-1:0]  cfg_r2r,
    input  logic [A2D_W-1:0]  cfg_a2d,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WIDEST = (A2D_W > CNT_W) ? A2D_W : CNT_W;
    localparam int LEN_W  = WIDEST + 1;

    seq_state_e        state, state_nxt;
    cyc_kind_e         cur_kind, prev_kind;
    logic              prev_vld;
    logic [DATA_W-1:0] cur_data;
    logic [LEN_W-1:0]  gap_len_q, gap_len, phase_len;
    logic [LEN_W-1:0]  low_len, high_len, acc_len, cs_len, elapsed;
    logic              gap_need, last, accept, is_read, ce_act;
    logic [A2D_W-1:0]  a2d_use;

    // legacy variant keeps one bit fewer of the address-to-data count
    generate
        if (A2D_NARROW) begin : g_a2d_narrow
            assign a2d_use = {1'b0, cfg_a2d[A2D_W-2:0]};
        end else begin : g_a2d_full
            assign a2d_use = cfg_a2d;
        end
    endgenerate

    assign accept  = req_valid && (state == ST_IDLE);
    assign is_read = (cur_kind == CYC_RD);

    nsg_gap_sel #(.CNT_W(CNT_W), .A2D_W(A2D_W), .LEN_W(LEN_W)) gap_i (
        .prev_vld (prev_vld),
        .prev_kind(prev_kind),
        .new_kind (cyc_kind_e'(req_type)),
        .w2r_cfg  (cfg_w2r),
        .r2w_cfg  (cfg_r2w),
        .r2r_cfg  (cfg_r2r),
        .a2d_cfg  (a2d_use),
        .need     (gap_need),
        .len      (gap_len)
    );

    nsg_len_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .CLK_MULT(CLK_MULT)) len_i (
        .lo_cfg  (cfg_lo),
        .hi_cfg  (cfg_hi),
        .acc_cfg (cfg_acc),
        .cs_cfg  (cfg_cs_setup),
        .is_read (is_read),
        .low_len (low_len),
        .high_len(high_len),
        .acc_len (acc_len),
        .cs_len  (cs_len)
    );

    always_comb begin
        unique case (state)
            ST_GAP:   phase_len = gap_len_q;
            ST_SETUP: phase_len = cs_len;
            ST_LOW:   phase_len = low_len;
            ST_HIGH:  phase_len = high_len;
            default:  phase_len = LEN_W'(1);
        endcase
    end

    nsg_phase_timer #(.LEN_W(LEN_W)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(state_nxt != state),
        .len    (phase_len),
        .elapsed(elapsed),
        .last   (last)
    );

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nxt = gap_need ? ST_GAP : ST_SETUP;
            ST_GAP:   if (last)      state_nxt = ST_SETUP;
            ST_SETUP: if (last)      state_nxt = ST_LOW;
            ST_LOW:   if (last)      state_nxt = ST_HIGH;
            ST_HIGH:  if (last)      state_nxt = ST_IDLE;
            default:                 state_nxt = ST_IDLE;
        endcase
    end

    // state register and per-cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_kind  <= CYC_CMD;
            cur_data  <= '0;
            prev_kind <= CYC_CMD;
            prev_vld  <= 1'b0;
            gap_len_q <= LEN_W'(1);
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            state    <= state_nxt;
            rd_valid <= 1'b0;
            if (accept) begin
                cur_kind  <= cyc_kind_e'(req_type);
                cur_data  <= req_data;
                gap_len_q <= gap_len;
            end
            if (state == ST_HIGH && last) begin
                prev_kind <= cur_kind;
                prev_vld  <= 1'b1;
            end
            if (state == ST_LOW && is_read && elapsed == acc_len - 1'b1) begin
                rd_valid <= 1'b1;
                rd_data  <= dq_in;
            end
        end
    end

    // pin outputs
    always_comb begin
        ce_act    = (state == ST_SETUP) || (state == ST_LOW) || (state == ST_HIGH);
        req_ready = (state == ST_IDLE);
        ce_n      = !ce_act;
        cle       = ce_act && (cur_kind == CYC_CMD);
        ale       = ce_act && (cur_kind == CYC_ADDR);
        we_n      = !((state == ST_LOW) && !is_read);
        re_n      = !((state == ST_LOW) && is_read);
        dq_oe     = ce_act && !is_read;
        dq_out    = cur_data;
    end
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic dq_oe,
    input logic rd_valid
);
    p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    p_bus_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);

    p_strobe_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    p_sample_after_re_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(re_n));

    p_rdv_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_ready_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && we_n && re_n));

    p_accept_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind nand_strobe_gen nsg_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .we_n     (we_n),
    .re_n     (re_n),
    .dq_oe    (dq_oe),
    .rd_valid (rd_valid)
);

// File: tb/nand_strobe_gen_tb_top.sv
module nand_strobe_gen_tb_top;
    localparam int MULT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_type = 2'd0;
    logic [7:0] req_data = 8'd0;
    logic [5:0] cfg_cs_setup = '0, cfg_lo = '0, cfg_hi = '0, cfg_acc = '0;
    logic [5:0] cfg_w2r = '0, cfg_r2w = '0, cfg_r2r = '0;
    logic [6:0] cfg_a2d = '0;
    logic       ce_n, cle, ale, we_n, re_n, dq_oe, rd_valid;
    logic [7:0] dq_out, rd_data;
    logic [7:0] dq_in = 8'd0;

    always #10 clk = ~clk;

    nand_strobe_gen #(.CLK_MULT(MULT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_data(req_data), .cfg_cs_setup(cfg_cs_setup),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_acc(cfg_acc), .cfg_w2r(cfg_w2r),
        .cfg_r2w(cfg_r2w), .cfg_r2r(cfg_r2r), .cfg_a2d(cfg_a2d), .ce_n(ce_n),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct {
        int         setup, low, high, gap;
        bit         chk_gap, is_read, is_cmd, is_addr;
        logic [7:0] data;
    } exp_cyc_t;

    exp_cyc_t   exp_q[$];
    logic [7:0] rd_q[$];
    int checks = 0, errors = 0;
    int prev_k = -1;
    bit linked = 0;
    int rd_seq = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int gap_for(input int pk, input int nk);
        if (pk < 0) return 0;
        if (nk == 3) begin
            if (pk == 3) return eff(int'(cfg_r2r));
            if (pk == 1) return eff(int'(cfg_a2d));
            return eff(int'(cfg_w2r));
        end
        if (pk == 3) return eff(int'(cfg_r2w));
        if (pk == 1 && nk == 2) return eff(int'(cfg_a2d));
        return 0;
    endfunction

    // driver: pushes expectations, then presents the request
    task automatic send(input int k, input logic [7:0] d);
        exp_cyc_t e;
        int fl;
        e.setup = eff(int'(cfg_cs_setup));
        e.high  = eff(int'(cfg_hi));
        fl      = (e.high >= MULT) ? 1 : MULT - e.high;
        e.low   = (eff(int'(cfg_lo)) > fl) ? eff(int'(cfg_lo)) : fl;
        if (k == 3 && eff(int'(cfg_acc)) > e.low) e.low = eff(int'(cfg_acc));
        e.gap     = gap_for(prev_k, k);
        e.chk_gap = linked;
        e.is_read = (k == 3);
        e.is_cmd  = (k == 0);
        e.is_addr = (k == 1);
        e.data    = d;
        exp_q.push_back(e);
        if (k == 3) begin
            rd_seq++;
            rd_q.push_back({4'(rd_seq), 4'(eff(int'(cfg_acc)))});
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_type  = 2'(k);
        req_data  = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(!req_ready, "R13 ready drop after accept", req_ready, 0);
        prev_k = k;
        linked = 1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0 || rd_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        linked = 0;
    endtask

    // flash read model: byte = {read number, clocks RE# has been low}
    int lowcnt = 0, ridx_m = 0;
    always @(negedge clk) begin
        if (!re_n) begin
            if (lowcnt == 0) ridx_m++;
            lowcnt++;
        end else lowcnt = 0;
        dq_in = {4'(ridx_m), 4'(lowcnt)};
    end

    // monitor: measures each cycle's phases and compares against the queue
    int ph = 0, hi_run = 0, gap_meas = 0, s_run = 0, we_run = 0, re_run = 0, h_run = 0;
    int cle_run = 0, ale_run = 0, oe_run = 0;
    logic [7:0] wdata;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ce_n) begin
                if (ph != 0) begin
                    if (exp_q.size() == 0) chk(0, "R2 unexpected cycle", 1, 0);
                    else begin
                        exp_cyc_t e;
                        int tot;
                        e   = exp_q.pop_front();
                        tot = e.setup + e.low + e.high;
                        chk(s_run == e.setup, "R3 CE setup", s_run, e.setup);
                        chk((e.is_read ? re_run : we_run) == e.low, "R4 R5 R6 strobe low", e.is_read ? re_run : we_run, e.low);
                        chk((e.is_read ? we_run : re_run) == 0, "R2 wrong strobe", e.is_read ? we_run : re_run, 0);
                        chk(h_run == e.high, "R4 strobe high", h_run, e.high);
                        chk(cle_run == (e.is_cmd ? tot : 0), "R2 CLE span", cle_run, e.is_cmd ? tot : 0);
                        chk(ale_run == (e.is_addr ? tot : 0), "R2 ALE span", ale_run, e.is_addr ? tot : 0);
                        chk(oe_run == (e.is_read ? 0 : tot), "R2 bus drive", oe_run, e.is_read ? 0 : tot);
                        if (!e.is_read) chk(wdata == e.data, "R2 bus data", wdata, e.data);
                        if (e.chk_gap) chk(gap_meas == 1 + e.gap, "R7 R8 R9 R10 R11 gap", gap_meas, 1 + e.gap);
                    end
                    ph = 0;
                end
                hi_run++;
            end else begin
                if (ph == 0) begin
                    gap_meas = hi_run; hi_run = 0; ph = 1;
                    s_run = 0; we_run = 0; re_run = 0; h_run = 0;
                    cle_run = 0; ale_run = 0; oe_run = 0;
                end
                if (ph == 1 && (!we_n || !re_n)) ph = 2;
                if (ph == 2 && we_n && re_n) ph = 3;
                if (ph == 1) s_run++;
                if (ph == 2) begin
                    if (!we_n) we_run++;
                    if (!re_n) re_run++;
                    wdata = dq_out;
                end
                if (ph == 3) h_run++;
                if (cle) cle_run++;
                if (ale) ale_run++;
                if (dq_oe) oe_run++;
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) chk(0, "R6 unexpected rd_valid", 1, 0);
                else begin
                    logic [7:0] x;
                    x = rd_q.pop_front();
                    chk(rd_data == x, "R6 read sample", rd_data, x);
                end
            end
        end
    end

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R13 watchdog: actual hung expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce_n && we_n && re_n, "R1 strobes idle", {ce_n, we_n, re_n}, 7);
        chk(!cle && !ale && !dq_oe, "R1 latches/bus idle", {cle, ale, dq_oe}, 0);
        chk(req_ready && !rd_valid, "R1 ready", {req_ready, rd_valid}, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // config A: R3 R4 R7 R8 R9 R10 R11
        cfg_cs_setup = 6'd2; cfg_lo = 6'd3; cfg_hi = 6'd2; cfg_acc = 6'd2;
        cfg_w2r = 6'd3; cfg_r2w = 6'd4; cfg_r2r = 6'd5; cfg_a2d = 7'd6;
        @(negedge clk);
        send(0, 8'h80); send(1, 8'h11); send(1, 8'h22); send(2, 8'hA5);
        send(2, 8'h5A); send(0, 8'h10); send(3, 8'h00); send(3, 8'h00);
        send(0, 8'h30); send(1, 8'h44); send(3, 8'h00); send(2, 8'hC3);
        send(3, 8'h00); send(0, 8'h00);
        go_idle();

        // config B: all zero, R12 and R5 period floor
        cfg_cs_setup = 0; cfg_lo = 0; cfg_hi = 0; cfg_acc = 0;
        cfg_w2r = 0; cfg_r2w = 0; cfg_r2r = 0; cfg_a2d = 0;
        @(negedge clk);
        send(0, 8'h70); send(3, 8'h00); send(3, 8'h00); send(2, 8'h99);
        send(1, 8'h01); send(2, 8'h3C);
        go_idle();

        // config C: long access time R6, 7-bit address-to-data R10
        cfg_cs_setup = 6'd1; cfg_lo = 6'd2; cfg_hi = 6'd3; cfg_acc = 6'd6;
        cfg_w2r = 6'd2; cfg_r2w = 6'd1; cfg_r2r = 6'd2; cfg_a2d = 7'd70;
        @(negedge clk);
        send(1, 8'hE0); send(2, 8'h66); send(1, 8'hE1); send(3, 8'h00);
        go_idle();

        finish_sim();
    end
endmodule